// File: doc/BRIEF.md
# PCI Bus Initiator

This block is a single initiator for a shared 32-bit PCI-style bus. A local agent first loads up to 30 write words into the block's buffer. It then presents one request: target address, bus command code, burst length and direction. The block raises REQ#, waits for a grant while the bus is idle, and drives the address phase. It then runs the burst with IRDY#/TRDY#, bounded by DEVSEL# and STOP# from the target. The completion code goes back to the local side.

The block generates even parity over AD and C/BE# one clock after every phase it drives. It checks the parity of returned read data and pulses PERR# on a mismatch. A test input inverts the driven parity, so that error handling in a target can be exercised. Each read word is handed to the local side with its index. A one-cycle done pulse carries the final status.

Top module: `pci_bus_initiator`

## Requirements
- R1: During and after reset, REQ#, FRAME#, IRDY# and PERR# are high, AD is not driven, done is low and idle is high.
- R2: An accepted request pulls REQ# low. FRAME# falls only at a clock edge where GNT# is low and the bus FRAME# and IRDY# inputs are both high, so a busy bus holds off the address phase.
- R3: The address phase lasts one clock. In it, FRAME# is low, AD carries the target address and C/BE# carries the command code. In the following data phases C/BE# is 0000, IRDY# is low and REQ# is released.
- R4: Beat i completes at an edge where IRDY#, TRDY# and DEVSEL# are all low. A write drives buffer word i on AD. A read returns the sampled AD one clock later on rd_data with rd_idx = i. FRAME# is high during the final data phase, and IRDY# is high after the last beat.
- R5: In the clock after an address or write data phase, PAR is driven and equals the XOR of the 32 AD bits and the 4 C/BE# bits of that phase.
- R6: While force_par_err is high, every driven PAR value is inverted.
- R7: PAR is sampled one clock after each read beat. On a mismatch, PERR# goes low in the next clock, and the transaction ends with status 4 (parity error).
- R8: DEVSEL# is sampled at five edges, starting at the edge after FRAME# falls. If it is low at none of them, FRAME# and IRDY# are released after the fifth edge, no beat completes, and the status is 1 (master abort).
- R9: STOP# low ends the transaction and releases FRAME# and IRDY#. If no beat has completed, the status is 2 (retry). Otherwise it is 3 (disconnect), and a beat taken with TRDY# on that edge counts.
- R10: One clock after the bus is released, done pulses for one cycle with the status on status_o (0 = normal completion), and idle is high from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Request strobe, taken while idle |
| cmd_addr | input | 32 | Target address |
| cmd_code | input | 4 | Bus command code |
| cmd_len | input | 5 | Beat count, 1 to 30 |
| cmd_write | input | 1 | 1 = write, 0 = read |
| wd_load | input | 1 | Write-buffer load strobe |
| wd_idx | input | 5 | Write-buffer word index |
| wd_data | input | 32 | Write-buffer word |
| force_par_err | input | 1 | Invert driven parity |
| rd_valid_o | output | 1 | Read word valid |
| rd_idx_o | output | 5 | Read word index |
| rd_data_o | output | 32 | Read word |
| done_o | output | 1 | Transaction finished pulse |
| status_o | output | 3 | Completion code |
| idle_o | output | 1 | No request pending |
| req_n_o | output | 1 | Bus request, active low |
| gnt_n | input | 1 | Bus grant, active low |
| frame_n_i | input | 1 | Observed bus FRAME# |
| irdy_n_i | input | 1 | Observed bus IRDY# |
| frame_n_o | output | 1 | Driven FRAME# |
| irdy_n_o | output | 1 | Driven IRDY# |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop, active low |
| devsel_n | input | 1 | Target claim, active low |
| ad_o | output | 32 | Driven AD value |
| ad_oe_o | output | 1 | AD drive enable |
| ad_i | input | 32 | Sampled AD value |
| cbe_n_o | output | 4 | Driven C/BE# |
| par_o | output | 1 | Driven parity |
| par_oe_o | output | 1 | Parity drive enable |
| par_i | input | 1 | Sampled parity |
| perr_n_o | output | 1 | Parity error, active low |

## Verification
The bench targets the DEVSEL# window at its last sampled edge. A claim there must still go through, while silence must abort exactly after the fifth edge; an off-by-one timer either aborts a valid claim or holds the bus a clock too long. It also covers a STOP# with no data against one that comes after data. A design that does not count beats correctly here reports retry and disconnect the wrong way round. Other cases are a 30-beat burst, which catches a beat counter or FRAME# release that is off by one at the buffer's end; bad parity on the final read beat, which a design that reports done before the late check would miss; and a foreign FRAME# held low while granted, which a master that ignores bus idle would drive over.

// File: rtl/pci_init_pkg.sv
package pci_init_pkg;
    localparam int PCI_DW = 32;
    localparam int PCI_CW = 4;

    typedef enum logic [2:0] {
        ST_OK    = 3'd0,
        ST_ABORT = 3'd1,
        ST_RETRY = 3'd2,
        ST_DISC  = 3'd3,
        ST_PERR  = 3'd4
    } txn_stat_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_REQ,
        PH_ADDR,
        PH_DATA,
        PH_FIN
    } phase_e;

    typedef struct packed {
        logic [PCI_DW-1:0] addr;
        logic [PCI_CW-1:0] cmd;
        logic              wr;
    } txn_req_t;

    function automatic logic even_par(input logic [PCI_DW-1:0] ad,
                                      input logic [PCI_CW-1:0] cbe);
        return ^{ad, cbe};
    endfunction
endpackage

// File: rtl/pci_wdata_buf.sv
module pci_wdata_buf
    import pci_init_pkg::*;
#(
    parameter int DEPTH = 30,
    parameter int IW    = 5
) (
    input  logic              clk,
    input  logic              ld,
    input  logic [IW-1:0]     ld_idx,
    input  logic [PCI_DW-1:0] ld_data,
    input  logic [IW-1:0]     rd_idx,
    output logic [PCI_DW-1:0] rd_data
);
    logic [PCI_DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (ld && (32'(ld_idx) < DEPTH))
            mem[ld_idx] <= ld_data;
    end

    assign rd_data = (32'(rd_idx) < DEPTH) ? mem[rd_idx] : '0;
endmodule

// File: rtl/pci_devsel_timer.sv
module pci_devsel_timer #(
    parameter int LIMIT = 5,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic hit
);
    logic [CW-1:0] cnt;

    assign hit = (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (run && !hit)
            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/pci_par_unit.sv
module pci_par_unit
    import pci_init_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              drv_en,
    input  logic [PCI_DW-1:0] drv_ad,
    input  logic [PCI_CW-1:0] drv_cbe,
    input  logic              inject,
    output logic              par_o,
    output logic              par_oe_o,
    input  logic              chk_arm,
    input  logic [PCI_DW-1:0] chk_ad,
    input  logic [PCI_CW-1:0] chk_cbe,
    input  logic              par_in,
    output logic              chk_bad,
    output logic              perr_n_o
);
    logic              pend;
    logic [PCI_DW-1:0] word_q;
    logic [PCI_CW-1:0] cbe_q;

    assign chk_bad = pend && (par_in != even_par(word_q, cbe_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            par_o    <= 1'b0;
            par_oe_o <= 1'b0;
            pend     <= 1'b0;
            word_q   <= '0;
            cbe_q    <= '0;
            perr_n_o <= 1'b1;
        end else begin
            par_oe_o <= drv_en;
            par_o    <= drv_en ? (even_par(drv_ad, drv_cbe) ^ inject) : 1'b0;
            pend     <= chk_arm;
            if (chk_arm) begin
                word_q <= chk_ad;
                cbe_q  <= chk_cbe;
            end
            perr_n_o <= !chk_bad;
        end
    end
endmodule

// File: rtl/pci_bus_initiator.sv
module pci_bus_initiator
    import pci_init_pkg::*;
#(
    parameter int MAX_BEATS  = 30,
    parameter int DEVSEL_TMO = 5,
    parameter int IW         = $clog2(MAX_BEATS),
    parameter int LW         = $clog2(MAX_BEATS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [PCI_DW-1:0] cmd_addr,
    input  logic [PCI_CW-1:0] cmd_code,
    input  logic [LW-1:0]     cmd_len,
    input  logic              cmd_write,
    input  logic              wd_load,
    input  logic [IW-1:0]     wd_idx,
    input  logic [PCI_DW-1:0] wd_data,
    input  logic              force_par_err,
    output logic              rd_valid_o,
    output logic [IW-1:0]     rd_idx_o,
    output logic [PCI_DW-1:0] rd_data_o,
    output logic              done_o,
    output logic [2:0]        status_o,
    output logic              idle_o,
    output logic              req_n_o,
    input  logic              gnt_n,
    input  logic              frame_n_i,
    input  logic              irdy_n_i,
    output logic              frame_n_o,
    output logic              irdy_n_o,
    input  logic              trdy_n,
    input  logic              stop_n,
    input  logic              devsel_n,
    output logic [PCI_DW-1:0] ad_o,
    output logic              ad_oe_o,
    input  logic [PCI_DW-1:0] ad_i,
    output logic [PCI_CW-1:0] cbe_n_o,
    output logic              par_o,
    output logic              par_oe_o,
    input  logic              par_i,
    output logic              perr_n_o
);
    phase_e            ph;
    txn_req_t          rq;
    logic [LW-1:0]     len_q;
    logic [LW-1:0]     beat;
    logic              xfer_any;
    logic              devsel_seen;
    logic              perr_seen;
    txn_stat_e         base_st;
    logic [PCI_DW-1:0] wbuf_word;
    logic              tmo_hit;
    logic              chk_bad;

    logic dev_ok, take, last_beat, next_last, abort_now, bus_free;

    assign dev_ok    = devsel_seen || !devsel_n;
    assign take      = (ph == PH_DATA) && !trdy_n && !devsel_n;
    assign last_beat = (beat == len_q - LW'(1));
    assign next_last = ((beat + LW'(1)) == (len_q - LW'(1)));
    assign abort_now = (ph == PH_DATA) && !dev_ok && tmo_hit;
    assign bus_free  = !gnt_n && frame_n_i && irdy_n_i;

    assign idle_o  = (ph == PH_IDLE);
    assign ad_oe_o = (ph == PH_ADDR) || ((ph == PH_DATA) && rq.wr);
    assign ad_o    = (ph == PH_ADDR) ? rq.addr :
                     (((ph == PH_DATA) && rq.wr) ? wbuf_word : '0);
    assign cbe_n_o = (ph == PH_ADDR) ? rq.cmd :
                     ((ph == PH_DATA) ? '0 : '1);

    pci_wdata_buf #(.DEPTH(MAX_BEATS), .IW(IW)) u_wbuf (
        .clk     (clk),
        .ld      (wd_load),
        .ld_idx  (wd_idx),
        .ld_data (wd_data),
        .rd_idx  (beat[IW-1:0]),
        .rd_data (wbuf_word)
    );

    pci_devsel_timer #(.LIMIT(DEVSEL_TMO)) u_tmo (
        .clk (clk),
        .rst (rst),
        .clr (ph == PH_REQ),
        .run ((ph == PH_ADDR) || (ph == PH_DATA)),
        .hit (tmo_hit)
    );

    pci_par_unit u_par (
        .clk      (clk),
        .rst      (rst),
        .drv_en   (ad_oe_o),
        .drv_ad   (ad_o),
        .drv_cbe  (cbe_n_o),
        .inject   (force_par_err),
        .par_o    (par_o),
        .par_oe_o (par_oe_o),
        .chk_arm  (take && !rq.wr),
        .chk_ad   (ad_i),
        .chk_cbe  (cbe_n_o),
        .par_in   (par_i),
        .chk_bad  (chk_bad),
        .perr_n_o (perr_n_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph          <= PH_IDLE;
            rq          <= '0;
            len_q       <= '0;
            beat        <= '0;
            xfer_any    <= 1'b0;
            devsel_seen <= 1'b0;
            perr_seen   <= 1'b0;
            base_st     <= ST_OK;
            req_n_o     <= 1'b1;
            frame_n_o   <= 1'b1;
            irdy_n_o    <= 1'b1;
            done_o      <= 1'b0;
            status_o    <= ST_OK;
            rd_valid_o  <= 1'b0;
            rd_idx_o    <= '0;
            rd_data_o   <= '0;
        end else begin
            done_o     <= 1'b0;
            rd_valid_o <= 1'b0;
            if (chk_bad)
                perr_seen <= 1'b1;
            unique case (ph)
                PH_IDLE: begin
                    if (cmd_valid) begin
                        rq      <= '{addr: cmd_addr, cmd: cmd_code, wr: cmd_write};
                        len_q   <= cmd_len;
                        req_n_o <= 1'b0;
                        ph      <= PH_REQ;
                    end
                end
                PH_REQ: begin
                    if (bus_free) begin
                        frame_n_o   <= 1'b0;
                        beat        <= '0;
                        xfer_any    <= 1'b0;
                        devsel_seen <= 1'b0;
                        perr_seen   <= 1'b0;
                        ph          <= PH_ADDR;
                    end
                end
                PH_ADDR: begin
                    irdy_n_o    <= 1'b0;
                    req_n_o     <= 1'b1;
                    devsel_seen <= !devsel_n;
                    if (len_q <= LW'(1))
                        frame_n_o <= 1'b1;
                    ph <= PH_DATA;
                end
                PH_DATA: begin
                    devsel_seen <= dev_ok;
                    if (abort_now) begin
                        frame_n_o <= 1'b1;
                        irdy_n_o  <= 1'b1;
                        base_st   <= ST_ABORT;
                        ph        <= PH_FIN;
                    end else begin
                        if (take) begin
                            beat     <= beat + LW'(1);
                            xfer_any <= 1'b1;
                            if (!rq.wr) begin
                                rd_valid_o <= 1'b1;
                                rd_idx_o   <= beat[IW-1:0];
                                rd_data_o  <= ad_i;
                            end
                        end
                        if (!stop_n) begin
                            frame_n_o <= 1'b1;
                            irdy_n_o  <= 1'b1;
                            base_st   <= (take || xfer_any) ? ST_DISC : ST_RETRY;
                            ph        <= PH_FIN;
                        end else if (take && last_beat) begin
                            frame_n_o <= 1'b1;
                            irdy_n_o  <= 1'b1;
                            base_st   <= ST_OK;
                            ph        <= PH_FIN;
                        end else if (take && next_last) begin
                            frame_n_o <= 1'b1;
                        end
                    end
                end
                PH_FIN: begin
                    done_o   <= 1'b1;
                    status_o <= (perr_seen || chk_bad) ? ST_PERR : base_st;
                    ph       <= PH_IDLE;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pci_bus_initiator_chk.sv
module pci_bus_initiator_chk (
    input logic       clk,
    input logic       rst,
    input logic       gnt_n,
    input logic       frame_n_i,
    input logic       irdy_n_i,
    input logic       req_n_o,
    input logic       frame_n_o,
    input logic       irdy_n_o,
    input logic       done_o,
    input logic       idle_o,
    input logic [2:0] status_o
);
    // R2: the address phase only begins on a granted, idle bus
    a_r2_start_needs_grant: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_n_o) |-> $past(!gnt_n && frame_n_i && irdy_n_i));

    // R3: REQ# is never held while IRDY# is driven
    a_r3_req_off_in_data: assert property (@(posedge clk) disable iff (rst)
        !irdy_n_o |-> req_n_o);

    // R4: FRAME# low beyond the address clock means IRDY# is low
    a_r4_frame_then_irdy: assert property (@(posedge clk) disable iff (rst)
        (!frame_n_o && $past(!frame_n_o)) |-> !irdy_n_o);

    // R9: the bus is released by the time completion is reported
    a_r9_release_at_done: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (frame_n_o && irdy_n_o));

    // R10: completion coincides with the idle state
    a_r10_done_means_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> idle_o);

    // R10: the status code stays within the defined set
    a_r10_status_range: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (status_o <= 3'd4));
endmodule

bind pci_bus_initiator pci_bus_initiator_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .gnt_n     (gnt_n),
    .frame_n_i (frame_n_i),
    .irdy_n_i  (irdy_n_i),
    .req_n_o   (req_n_o),
    .frame_n_o (frame_n_o),
    .irdy_n_o  (irdy_n_o),
    .done_o    (done_o),
    .idle_o    (idle_o),
    .status_o  (status_o)
);

// File: tb/pci_bus_initiator_test.sv
module pci_bus_initiator_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    typedef struct packed {
        logic       wr;
        logic [4:0] len;
        logic [2:0] dev;    // edge at which DEVSEL# is first sampled low, 0 = never
        logic [1:0] skind;  // 0 none, 1 stop before data, 2 stop with beat sbeat
        logic [4:0] sbeat;
        logic       bad;
        logic [2:0] est;
        logic [4:0] ebeats;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd1,  3'd1, 2'd0, 5'd0, 1'b0, 3'd0, 5'd1},
        '{1'b1, 5'd4,  3'd2, 2'd0, 5'd0, 1'b0, 3'd0, 5'd4},
        '{1'b0, 5'd3,  3'd3, 2'd0, 5'd0, 1'b0, 3'd0, 5'd3},
        '{1'b0, 5'd30, 3'd1, 2'd0, 5'd0, 1'b0, 3'd0, 5'd30},
        '{1'b0, 5'd2,  3'd5, 2'd0, 5'd0, 1'b0, 3'd0, 5'd2},
        '{1'b1, 5'd3,  3'd0, 2'd0, 5'd0, 1'b0, 3'd1, 5'd0},
        '{1'b0, 5'd4,  3'd1, 2'd1, 5'd0, 1'b0, 3'd2, 5'd0},
        '{1'b1, 5'd6,  3'd2, 2'd2, 5'd2, 1'b0, 3'd3, 5'd2},
        '{1'b0, 5'd3,  3'd1, 2'd0, 5'd0, 1'b1, 3'd4, 5'd3},
        '{1'b0, 5'd5,  3'd1, 2'd2, 5'd3, 1'b0, 3'd3, 5'd3}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [3:0]  cmd_code = '0;
    logic [4:0]  cmd_len = '0;
    logic        cmd_write = 1'b0;
    logic        wd_load = 1'b0;
    logic [4:0]  wd_idx = '0;
    logic [31:0] wd_data = '0;
    logic        force_par_err = 1'b0;
    logic        gnt_n = 1'b1;
    logic        ext_frame_n = 1'b1;
    logic        trdy_n = 1'b1;
    logic        stop_n = 1'b1;
    logic        devsel_n = 1'b1;
    logic [31:0] ad_i = '0;
    logic        par_i = 1'b0;

    logic        rd_valid_o, done_o, idle_o, req_n_o, frame_n_o, irdy_n_o;
    logic        ad_oe_o, par_o, par_oe_o, perr_n_o;
    logic [4:0]  rd_idx_o;
    logic [31:0] rd_data_o, ad_o;
    logic [2:0]  status_o;
    logic [3:0]  cbe_n_o;
    logic        frame_n_bus, irdy_n_bus;

    assign frame_n_bus = ext_frame_n & frame_n_o;
    assign irdy_n_bus  = irdy_n_o;

    int checks = 0;
    int fails  = 0;

    pci_bus_initiator uut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_code(cmd_code),
        .cmd_len(cmd_len), .cmd_write(cmd_write),
        .wd_load(wd_load), .wd_idx(wd_idx), .wd_data(wd_data),
        .force_par_err(force_par_err),
        .rd_valid_o(rd_valid_o), .rd_idx_o(rd_idx_o), .rd_data_o(rd_data_o),
        .done_o(done_o), .status_o(status_o), .idle_o(idle_o),
        .req_n_o(req_n_o), .gnt_n(gnt_n),
        .frame_n_i(frame_n_bus), .irdy_n_i(irdy_n_bus),
        .frame_n_o(frame_n_o), .irdy_n_o(irdy_n_o),
        .trdy_n(trdy_n), .stop_n(stop_n), .devsel_n(devsel_n),
        .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ad_i(ad_i), .cbe_n_o(cbe_n_o),
        .par_o(par_o), .par_oe_o(par_oe_o), .par_i(par_i), .perr_n_o(perr_n_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] wpat(input int n, input int i);
        return {8'hA5, 8'(n), 8'h5A, 8'(i)};
    endfunction

    function automatic logic [31:0] rpat(input int n, input int i);
        return {8'h3C, 8'(i), 8'hC3, 8'(n)} ^ 32'h0101_0000;
    endfunction

    task automatic run_vec(input vec_t v, input int n, input logic frc, input int busy);
        logic [31:0] addr;
        logic [3:0]  cmd;
        logic        active, prev_take, prev_wr_take, tk, st, seen_done, rel_set;
        logic [31:0] prev_word;
        int k, beats, rcnt, perr_cnt, cyc, rel_k;
        addr = 32'h1000_0000 + 32'(n * 16);
        cmd  = v.wr ? 4'h7 : 4'h6;
        force_par_err = frc;
        for (int i = 0; i < int'(v.len); i++) begin
            @(negedge clk);
            wd_load = 1'b1; wd_idx = 5'(i); wd_data = wpat(n, i);
        end
        @(negedge clk);
        wd_load = 1'b0;
        cmd_valid = 1'b1; cmd_addr = addr; cmd_code = cmd;
        cmd_len = v.len; cmd_write = v.wr;
        if (busy > 0) ext_frame_n = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        active = 0; prev_take = 0; prev_wr_take = 0; prev_word = '0;
        k = 0; beats = 0; rcnt = 0; perr_cnt = 0; seen_done = 0;
        rel_set = 0; rel_k = 0;
        for (cyc = 0; cyc < 400; cyc++) begin
            if (!perr_n_o) perr_cnt++;
            if (rd_valid_o) begin
                chk(rd_idx_o == 5'(rcnt), "R4 rd_idx", rd_idx_o, rcnt);
                chk(rd_data_o == rpat(n, rcnt), "R4 rd_data", rd_data_o, rpat(n, rcnt));
                rcnt++;
            end
            if (done_o) begin
                seen_done = 1;
                break;
            end
            if (busy > 0 && cyc < busy) begin
                if (cyc == busy - 1) begin
                    chk(frame_n_o == 1'b1, "R2 held off by busy bus", frame_n_o, 1);
                    chk(req_n_o == 1'b0, "R2 request pending", req_n_o, 0);
                end
            end else begin
                ext_frame_n = 1'b1;
            end
            if (active) k++;
            if (!active && !frame_n_o) begin
                active = 1; k = 0;
                chk(ad_o == addr && ad_oe_o, "R3 address on AD", ad_o, addr);
                chk(cbe_n_o == cmd, "R3 command on C/BE#", cbe_n_o, cmd);
                chk(irdy_n_o == 1'b1, "R3 IRDY# high in address phase", irdy_n_o, 1);
            end
            if (active && k == 1) begin
                chk(par_oe_o && par_o == ((^{addr, cmd}) ^ frc),
                    frc ? "R6 inverted address parity" : "R5 address parity",
                    par_o, (^{addr, cmd}) ^ frc);
                chk(req_n_o == 1'b1, "R3 REQ# released", req_n_o, 1);
                if (!irdy_n_o)
                    chk(cbe_n_o == 4'h0, "R3 byte enables in data phase", cbe_n_o, 0);
            end
            if (prev_wr_take)
                chk(par_oe_o && par_o == ((^prev_word) ^ frc),
                    frc ? "R6 inverted write parity" : "R5 write parity",
                    par_o, (^prev_word) ^ frc);
            if (active && k > 0 && frame_n_o && irdy_n_o && !rel_set) begin
                rel_set = 1; rel_k = k;
            end
            // target response for the coming edge
            gnt_n = req_n_o;
            devsel_n = !(active && v.dev != 0 && (k + 1 >= int'(v.dev))
                         && !(frame_n_o && irdy_n_o));
            tk = 0; st = 0;
            if (active && !irdy_n_o && !devsel_n) begin
                if (v.skind == 2'd1) st = 1;
                else if (v.skind == 2'd2 && beats == int'(v.sbeat) - 1) begin tk = 1; st = 1; end
                else tk = 1;
            end
            if (tk && v.wr) begin
                chk(ad_o == wpat(n, beats) && ad_oe_o, "R4 write word on AD", ad_o, wpat(n, beats));
            end
            if (tk && v.skind == 2'd0)
                chk(frame_n_o == (beats == int'(v.len) - 1), "R4 FRAME# on final phase",
                    frame_n_o, beats == int'(v.len) - 1);
            par_i = (prev_take && !v.wr) ? ((^prev_word) ^ v.bad) : 1'b0;
            trdy_n = !tk;
            stop_n = !st;
            ad_i = v.wr ? 32'h0 : rpat(n, beats);
            prev_take = tk;
            prev_wr_take = tk && v.wr;
            prev_word = v.wr ? wpat(n, beats) : rpat(n, beats);
            if (tk) beats++;
            @(negedge clk);
        end
        trdy_n = 1'b1; stop_n = 1'b1; devsel_n = 1'b1; par_i = 1'b0; gnt_n = 1'b1;
        ext_frame_n = 1'b1;
        chk(seen_done == 1, "R10 done reported", seen_done, 1);
        chk(status_o == v.est, "R10 status", status_o, v.est);
        chk(idle_o == 1'b1, "R10 idle after done", idle_o, 1);
        chk(beats == int'(v.ebeats), "R4 beat count", beats, v.ebeats);
        if (!v.wr)
            chk(rcnt == int'(v.ebeats), "R4 read words returned", rcnt, v.ebeats);
        if (v.est == 3'd1)
            chk(rel_k == 5, "R8 abort after fifth edge", rel_k, 5);
        if (v.est == 3'd2 || v.est == 3'd3)
            chk(rel_set == 1, "R9 bus released on STOP#", rel_set, 1);
        if (v.bad && beats > 0)
            chk(perr_cnt > 0, "R7 PERR# asserted", perr_cnt, 1);
        else
            chk(perr_cnt == 0, "R7 PERR# quiet", perr_cnt, 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R10 done is one cycle", done_o, 0);
        force_par_err = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(req_n_o == 1'b1, "R1 REQ# in reset", req_n_o, 1);
        chk(frame_n_o && irdy_n_o, "R1 FRAME#/IRDY# in reset", {frame_n_o, irdy_n_o}, 2'b11);
        chk(perr_n_o == 1'b1 && !ad_oe_o, "R1 PERR#/AD in reset", {perr_n_o, ad_oe_o}, 2'b10);
        chk(idle_o && !done_o, "R1 idle in reset", {idle_o, done_o}, 2'b10);
        rst = 1'b0;
        @(negedge clk);
        chk(req_n_o && idle_o, "R1 after reset", {req_n_o, idle_o}, 2'b11);

        for (int n = 0; n < NV; n++)
            run_vec(VECS[n], n, 1'b0, 0);

        // R6: injected parity error on a write
        run_vec(VECS[1], 20, 1'b1, 0);
        // R2: foreign FRAME# holds off the address phase
        run_vec(VECS[0], 21, 1'b0, 6);
        // R7: bad parity on a single-beat read
        run_vec('{1'b0, 5'd1, 3'd2, 2'd0, 5'd0, 1'b1, 3'd4, 5'd1}, 22, 1'b0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule